// File: doc/BRIEF.md
# Paired-Channel PWM Bank with Wishbone Slave Port

This block drives an even number of pulse-width-modulated outputs whose duty settings are held in 32-bit registers on a Wishbone B4 slave port. Each register carries the settings of two neighbouring outputs. Its low field controls the even-numbered channel and its upper field controls the odd-numbered one. Registers occupy consecutive 32-bit words. Only the word-select bits of the address are decoded, so the interconnect is free to map the block anywhere.

One 12-bit period counter runs freely and is shared by every channel. Each output is the result of comparing that counter with the channel's duty value. Software sets a channel by writing its 12-bit field, and it can read the setting back at any time. The port accepts one transfer per cycle, never stalls, and returns the acknowledge exactly one cycle after each transfer.

Top module: `pwm_bank`

## Requirements
- R1: In register k, bits 11:0 hold the duty value of channel 2k and bits 27:16 hold the duty value of channel 2k+1. A read returns both values in those positions.
- R2: Bits 15:12 and 31:28 of every register always read as zero, whatever value was last written to them.
- R3: The register index is taken from address bits starting at bit 2, with as many bits as the register count needs. Address bits 1:0 and all bits above the index are ignored, so aliased addresses reach the same register.
- R4: A transfer is accepted in any cycle where wbCyc and wbStb are both high. wbAck is high in exactly the following cycle, with read data valid at that time. Back-to-back transfers produce one acknowledge per cycle. A write becomes visible to a read accepted in the next cycle.
- R5: wbStall is low in every cycle.
- R6: The period counter wraps from 4095 to 0. An output is high while the counter is below its duty value. Over any 4096 consecutive cycles, an output with duty d is therefore high for exactly d cycles, so duty 0 keeps the output low.
- R7: All channels share one counter. When a channel with a smaller duty value is high, every channel with an equal or larger duty value is also high.
- R8: After reset every duty value is zero, every output is low, wbAck is low and every register reads zero.
- R9: When wbCyc or wbStb is low, no transfer takes place. No acknowledge is produced and the registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wbCyc | input | 1 | Bus cycle in progress |
| wbStb | input | 1 | Transfer strobe |
| wbWe | input | 1 | 1 = write, 0 = read |
| wbAdr | input | ADDR_W | Byte address, only the word-select bits are decoded |
| wbDatW | input | 32 | Write data |
| wbDatR | output | 32 | Read data, valid with wbAck |
| wbAck | output | 1 | Transfer acknowledge |
| wbStall | output | 1 | Always low |
| pwmOut | output | CHAN_CNT | One PWM output per channel |

## Verification
A wrong duty value, field placement or reserved-bit store shows up on wbDatR in the acknowledge cycle of the next read of that register. It also appears on the affected output within one 4096-cycle period, as a high-time count different from the programmed duty. A fault in the counter or its sharing shows up within one period as an ordering violation between channels or as a wrong high-time count. Decode and handshake faults appear one cycle after the transfer, as a missing or extra acknowledge or as data from a neighbouring register.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  // Field width is fixed by the register layout (two fields per 32-bit word).
  localparam int DUTY_W    = 12;
  localparam int IDX_MAX_W = 8;
  localparam int LO_LSB    = 0;
  localparam int HI_LSB    = 16;

  typedef struct packed {
    logic                 wrEn;
    logic                 rdEn;
    logic [IDX_MAX_W-1:0] idx;
  } busStrobe_t;
endpackage

// File: rtl/pwm_bank_ctrl.sv
module pwm_bank_ctrl
  import pwm_bank_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [ADDR_W-1:0] wbAdr,
  output busStrobe_t        strobe,
  output logic              wbAck,
  output logic              wbStall
);
  logic accept;
  logic unusedAdrBits;

  assign accept  = wbCyc & wbStb;
  assign wbStall = 1'b0;

  always_comb begin
    strobe      = '0;
    strobe.wrEn = accept & wbWe;
    strobe.rdEn = accept & ~wbWe;
    strobe.idx  = IDX_MAX_W'(wbAdr[IDX_W+1:2]);
  end

  // Byte lanes and interconnect-owned upper bits are not decoded.
  assign unusedAdrBits = ^{wbAdr[1:0], wbAdr[ADDR_W-1:IDX_W+2]};

  always_ff @(posedge clk) begin
    if (rst) wbAck <= 1'b0;
    else     wbAck <= accept;
  end
endmodule

// File: rtl/pwm_bank_dp.sv
module pwm_bank_dp
  import pwm_bank_pkg::*;
#(
  parameter int CHAN_CNT = 4,
  parameter int CNT_W    = DUTY_W
) (
  input  logic                clk,
  input  logic                rst,
  input  busStrobe_t          strobe,
  input  logic [31:0]         wbDatW,
  output logic [31:0]         wbDatR,
  output logic [CHAN_CNT-1:0] pwmOut
);
  localparam int REG_CNT = CHAN_CNT / 2;

  logic [CHAN_CNT*DUTY_W-1:0] dutyVec;
  logic [31:0]                regWord [REG_CNT];
  logic [31:0]                rdSel;
  logic [CNT_W-1:0]           periodCnt;
  logic                       unusedResBits;

  // Reserved write bits are dropped, never stored.
  assign unusedResBits = ^{wbDatW[31:HI_LSB+DUTY_W], wbDatW[HI_LSB-1:LO_LSB+DUTY_W]};

  for (genvar r = 0; r < REG_CNT; r++) begin : g_reg
    logic [DUTY_W-1:0] loQ, hiQ;
    always_ff @(posedge clk) begin
      if (rst) begin
        loQ <= '0;
        hiQ <= '0;
      end else if (strobe.wrEn && strobe.idx == IDX_MAX_W'(r)) begin
        loQ <= wbDatW[LO_LSB +: DUTY_W];
        hiQ <= wbDatW[HI_LSB +: DUTY_W];
      end
    end
    assign dutyVec[(2*r)*DUTY_W   +: DUTY_W] = loQ;
    assign dutyVec[(2*r+1)*DUTY_W +: DUTY_W] = hiQ;
    always_comb begin
      regWord[r] = '0;
      regWord[r][LO_LSB +: DUTY_W] = loQ;
      regWord[r][HI_LSB +: DUTY_W] = hiQ;
    end
  end

  always_comb begin
    rdSel = '0;
    for (int r = 0; r < REG_CNT; r++)
      if (strobe.idx == IDX_MAX_W'(r)) rdSel = regWord[r];
  end

  always_ff @(posedge clk) begin
    if (rst)              wbDatR <= '0;
    else if (strobe.rdEn) wbDatR <= rdSel;
    else                  wbDatR <= '0;
  end

  // Free-running period counter, wraps at its full range.
  always_ff @(posedge clk) begin
    if (rst) periodCnt <= '0;
    else     periodCnt <= periodCnt + 1'b1;
  end

  for (genvar c = 0; c < CHAN_CNT; c++) begin : g_cmp
    assign pwmOut[c] = periodCnt < dutyVec[c*DUTY_W +: DUTY_W];
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int CHAN_CNT = 4,
  parameter int ADDR_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wbCyc,
  input  logic                wbStb,
  input  logic                wbWe,
  input  logic [ADDR_W-1:0]   wbAdr,
  input  logic [31:0]         wbDatW,
  output logic [31:0]         wbDatR,
  output logic                wbAck,
  output logic                wbStall,
  output logic [CHAN_CNT-1:0] pwmOut
);
  localparam int REG_CNT = CHAN_CNT / 2;
  localparam int IDX_W   = (REG_CNT > 1) ? $clog2(REG_CNT) : 1;

  if (CHAN_CNT % 2 != 0 || CHAN_CNT < 2) begin : g_bad_cnt
    $error("pwm_bank: CHAN_CNT must be even and at least 2");
  end
  if (IDX_W > IDX_MAX_W || ADDR_W <= IDX_W + 2) begin : g_bad_adr
    $error("pwm_bank: address width does not fit the register count");
  end

  busStrobe_t strobe;

  pwm_bank_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .strobe(strobe), .wbAck(wbAck), .wbStall(wbStall)
  );

  pwm_bank_dp #(.CHAN_CNT(CHAN_CNT)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wbDatW(wbDatW),
    .wbDatR(wbDatR), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_bank_checker.sv
module pwm_bank_checker #(
  parameter int CHAN_CNT = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                wbCyc,
  input logic                wbStb,
  input logic [31:0]         wbDatR,
  input logic                wbAck,
  input logic                wbStall,
  input logic [CHAN_CNT-1:0] pwmOut
);
  p_ack_next_r4: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb) |=> wbAck);

  p_no_ack_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !(wbCyc && wbStb) |=> !wbAck);

  p_stall_low_r5: assert property (@(posedge clk) disable iff (rst)
    !wbStall);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    wbAck |-> (wbDatR[31:28] == 4'h0 && wbDatR[15:12] == 4'h0));

  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |=> (pwmOut == '0 && !wbAck && wbDatR == '0));
endmodule

bind pwm_bank pwm_bank_checker #(.CHAN_CNT(CHAN_CNT)) u_chk (
  .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbDatR(wbDatR),
  .wbAck(wbAck), .wbStall(wbStall), .pwmOut(pwmOut)
);

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  localparam int CH = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic wbCyc = 0, wbStb = 0, wbWe = 0;
  logic [31:0] wbAdr = '0, wbDatW = '0, wbDatR;
  logic wbAck, wbStall;
  logic [CH-1:0] pwmOut;
  int nChecks = 0, nFail = 0;
  bit done = 0;
  logic [11:0] model [CH];
  logic [31:0] lf = 32'h1234_5677;

  always #2 clk = ~clk;

  pwm_bank #(.CHAN_CNT(CH), .ADDR_W(32)) u_pwm_bank (
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbDatW(wbDatW), .wbDatR(wbDatR), .wbAck(wbAck),
    .wbStall(wbStall), .pwmOut(pwmOut));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input int r);
    return {4'h0, model[2*r+1], 4'h0, model[2*r]};
  endfunction

  task automatic nextLf();
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
  endtask

  task automatic idle();
    wbCyc = 0; wbStb = 0; wbWe = 0;
  endtask

  task automatic busWrite(input logic [31:0] adr, input logic [31:0] dat);
    @(negedge clk);
    wbCyc = 1; wbStb = 1; wbWe = 1; wbAdr = adr; wbDatW = dat;
    @(negedge clk);
    idle();
    check(wbAck === 1'b1, "R4 write ack", {31'b0, wbAck}, 1);
    model[2*adr[2]]   = dat[11:0];
    model[2*adr[2]+1] = dat[27:16];
  endtask

  task automatic busRead(input logic [31:0] adr, input string req);
    @(negedge clk);
    wbCyc = 1; wbStb = 1; wbWe = 0; wbAdr = adr;
    @(negedge clk);
    idle();
    check(wbAck === 1'b1, "R4 read ack", {31'b0, wbAck}, 1);
    check(wbDatR === expWord(adr[2]), req, wbDatR, expWord(adr[2]));
  endtask

  task automatic measure(input string req);
    int hiCnt [CH];
    int orderErr = 0;
    for (int c = 0; c < CH; c++) hiCnt[c] = 0;
    repeat (4096) begin
      @(negedge clk);
      for (int a = 0; a < CH; a++) begin
        if (pwmOut[a]) hiCnt[a]++;
        for (int b = 0; b < CH; b++)
          if (pwmOut[a] && model[b] >= model[a] && !pwmOut[b]) orderErr++;
      end
    end
    for (int c = 0; c < CH; c++)
      check(hiCnt[c] == int'(model[c]), req, hiCnt[c], model[c]);
    check(orderErr == 0, "R7 shared counter ordering", orderErr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < CH; c++) model[c] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R8: reset state
    check(wbAck === 1'b0, "R8 ack after reset", {31'b0, wbAck}, 0);
    check(pwmOut === '0, "R8 outputs after reset", {28'b0, pwmOut}, 0);
    check(wbStall === 1'b0, "R5 stall low", {31'b0, wbStall}, 0);
    busRead(32'h0, "R8 reg0 reset zero");
    busRead(32'h4, "R8 reg1 reset zero");

    // R1/R2/R3: field sweep with reserved bits set and aliased addresses
    for (int p = 0; p < 64; p++) begin
      logic [31:0] aw, ar;
      nextLf();
      aw = {lf[31:8], 5'b0, p[0], lf[1:0]};
      ar = {~lf[31:8], 5'b0, p[0], ~lf[1:0]};
      busWrite(aw, lf);
      busRead(ar, "R1 R2 R3 readback via alias");
    end
    // R1: field boundaries per channel
    busWrite(32'h0, 32'h0FFF_0000);
    busRead(32'h0, "R1 hi field only");
    busWrite(32'h0, 32'h0000_0FFF);
    busRead(32'h0, "R1 lo field only");
    busWrite(32'h4, 32'hF000_F000);
    busRead(32'h4, "R2 reserved-only write reads zero");

    // R9: strobe without cycle, cycle without strobe
    @(negedge clk);
    wbCyc = 0; wbStb = 1; wbWe = 1; wbAdr = 32'h0; wbDatW = 32'h0ABC_0DEF;
    @(negedge clk);
    check(wbAck === 1'b0, "R9 no ack without cyc", {31'b0, wbAck}, 0);
    wbCyc = 1; wbStb = 0;
    @(negedge clk);
    check(wbAck === 1'b0, "R9 no ack without stb", {31'b0, wbAck}, 0);
    idle();
    busRead(32'h0, "R9 register unchanged");

    // R4: pipelined write then reads back-to-back
    @(negedge clk);
    wbCyc = 1; wbStb = 1; wbWe = 1; wbAdr = 32'h4; wbDatW = 32'h0123_0456;
    @(negedge clk);
    check(wbAck === 1'b1, "R4 pipelined write ack", {31'b0, wbAck}, 1);
    model[2] = 12'h456; model[3] = 12'h123;
    wbWe = 0; wbAdr = 32'h4;
    @(negedge clk);
    check(wbAck === 1'b1 && wbDatR === expWord(1), "R4 read right after write", wbDatR, expWord(1));
    wbAdr = 32'h0;
    @(negedge clk);
    check(wbAck === 1'b1 && wbDatR === expWord(0), "R4 pipelined read reg0", wbDatR, expWord(0));
    idle();
    @(negedge clk);
    check(wbAck === 1'b0, "R4 single ack per request", {31'b0, wbAck}, 0);

    // R6/R7: PWM high-time per period
    busWrite(32'h0, {4'h0, 12'd1, 4'h0, 12'd0});
    busWrite(32'h4, {4'h0, 12'd4095, 4'h0, 12'd2048});
    measure("R6 high time pattern A");
    busWrite(32'h0, {4'h0, 12'd100, 4'h0, 12'd4095});
    busWrite(32'h4, {4'h0, 12'd4094, 4'h0, 12'd100});
    measure("R6 high time pattern B");
    check(wbStall === 1'b0, "R5 stall low at end", {31'b0, wbStall}, 0);

    // R8: reset clears registers again
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int c = 0; c < CH; c++) model[c] = '0;
    check(pwmOut === '0, "R8 outputs after second reset", {28'b0, pwmOut}, 0);
    busRead(32'h4, "R8 reg1 cleared");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule